// File: doc/BRIEF.md
# Dual-Width Flash Bus Front End

This block sits at the pin side of a parallel NOR-style flash device. Each clock it samples the three active-low strobes (chip select, output enable, write enable), the width select, the word address, the identifier-mode input and the 16-bit data bus. It decides which bus mode applies: standby, output off, read, write or clash. In a read it steers array data, a fixed identifier code or the status byte onto the bus. Every data pin has its own output enable, so the block drives the bus correctly in both 16-bit and 8-bit width.

In 8-bit width the top data pin stops being data and becomes the lowest byte-address bit. It chooses which half of the addressed word appears on the low lane, and on writes it becomes the low bit of the captured byte address. When a write strobe ends, the address and data sampled during the last strobe cycle go to the command logic with a one-cycle valid pulse. The array and the command state machine are outside the block. The block sees the array as an address output and a data input, and sees the command logic as a read-source select input and the write outputs.

Top module: `flash_bus_front`

## Requirements
- R1: While the sampled chip select is high (standby), every `dq_oe` bit is 0 whatever the other strobes are, and no write is captured.
- R2: With chip select low, output enable high and write enable high, every `dq_oe` bit is 0.
- R3: A read is chip select low, output enable low and write enable high. In a 16-bit read (`wide`=1) with the array source, all 16 `dq_oe` bits are 1 and `dq_out` equals `array_data`. `arr_addr` equals the sampled address. Outputs follow the pins one clock after sampling.
- R4: In an 8-bit read (`wide`=0) only `dq_oe[7:0]` are 1, and bits 15:8 (including 14:8) are 0. `dq_in[15]`=0 puts array bits 7:0 on `dq_out[7:0]`. `dq_in[15]`=1 puts bits 15:8 there.
- R5: Identifier reads return a code chosen by address bits 1:0. 00 gives C2h, 01 gives F7h, and 10 or 11 give 00h. The `id_mode` input forces the identifier source over `rd_src`.
- R6: A 16-bit identifier read drives `dq_out[15:8]` as 00h with all 16 enables set. An 8-bit identifier read leaves bits 15:8 undriven and ignores `dq_in[15]`.
- R7: A status read drives `status_byte` on `dq_out[7:0]` and leaves `dq_oe[15:8]` at 0 in both widths.
- R8: The write strobe is chip select low, write enable low and output enable high. The bus stays undriven while it is active. Suppose the first sample with the strobe released is taken at edge E. Then `wr_valid` is 1 for exactly the one cycle after edge E+1. It carries the address and data sampled at the last strobed edge. In 16-bit width, `wr_addr` = {address, 0} and `wr_data` is the full bus. The strobe may end by write enable or by chip select rising.
- R9: In 8-bit width, `wr_data` = {00h, `dq_in[7:0]`} and `wr_addr` bit 0 is `dq_in[15]`.
- R10: Output enable and write enable both low with chip select low is a clash. Nothing is driven, and a clash held from a non-write state gives no `wr_valid`.
- R11: `rd_src` encoding: 0 = array, 1 = identifier, 2 = status, 3 = array.
- R12: During and right after reset, all `dq_oe` bits and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| id_mode | input | 1 | Identifier-mode pin (stands in for the high-voltage address level) |
| addr | input | 20 | Word address |
| dq_in | input | 16 | Data bus input side; bit 15 is the byte address in 8-bit width |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-pin output enable |
| rd_src | input | 2 | Read source from command logic (R11 encoding) |
| array_data | input | 16 | Word read from the array at `arr_addr` |
| status_byte | input | 8 | Status register value |
| arr_addr | output | 20 | Word address to the array |
| wr_valid | output | 1 | One-cycle write capture pulse |
| wr_addr | output | 21 | Captured byte address {word address, byte bit} |
| wr_data | output | 16 | Captured write data |

## Verification
A wrong decoded mode appears on `dq_oe` in the cycle after the pins are sampled. The bench compares every enable bit on every clock, so a bad decode of standby, clash or width is reported at once. A wrong steering choice, such as the wrong byte half, identifier code or status lane, shows on the enabled `dq_out` bits in that same cycle. A fault in the write-capture history shows two cycles after the strobe is released, as a missing, doubled or mistimed `wr_valid` or as wrong captured fields.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_OUT_OFF = 3'd1,
    M_READ    = 3'd2,
    M_WRITE   = 3'd3,
    M_CLASH   = 3'd4
  } bus_mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_SPARE  = 2'd3
  } rd_src_e;

  // Mode from the three active-low strobes; chip select dominates.
  function automatic bus_mode_e decode_mode(logic cs_n, logic rd_n, logic wr_n);
    bus_mode_e m;
    if (cs_n)               m = M_STANDBY;
    else if (!rd_n && !wr_n) m = M_CLASH;
    else if (!rd_n)          m = M_READ;
    else if (!wr_n)          m = M_WRITE;
    else                     m = M_OUT_OFF;
    return m;
  endfunction

  // Fixed identifier code picked by the two lowest address bits.
  function automatic logic [7:0] ident_code(logic [1:0] sel, logic [7:0] mfr,
                                            logic [7:0] dev);
    logic [7:0] c;
    case (sel)
      2'b00:   c = mfr;
      2'b01:   c = dev;
      default: c = 8'h00;
    endcase
    return c;
  endfunction

  // Effective read source after the identifier pin override.
  function automatic rd_src_e resolve_src(logic id_pin, logic [1:0] req);
    rd_src_e s;
    if (id_pin)          s = SRC_IDENT;
    else if (req == 2'd1) s = SRC_IDENT;
    else if (req == 2'd2) s = SRC_STATUS;
    else                  s = SRC_ARRAY;
    return s;
  endfunction

endpackage

// File: rtl/fbi_pin_sampler.sv
module fbi_pin_sampler #(
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide,
  input  logic              id_mode,
  input  logic [1:0]        rd_src,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              s_ce_n,
  output logic              s_oe_n,
  output logic              s_we_n,
  output logic              s_wide,
  output logic              s_id,
  output logic [1:0]        s_src,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DQ_W-1:0]   s_dq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ce_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_we_n <= 1'b1;
      s_wide <= 1'b1;
      s_id   <= 1'b0;
      s_src  <= 2'd0;
      s_addr <= '0;
      s_dq   <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_oe_n <= oe_n;
      s_we_n <= we_n;
      s_wide <= wide;
      s_id   <= id_mode;
      s_src  <= rd_src;
      s_addr <= addr;
      s_dq   <= dq_in;
    end
  end

endmodule

// File: rtl/fbi_read_steer.sv
module fbi_read_steer
  import fbi_pkg::*;
#(
  parameter int         DQ_W     = 16,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bus_mode_e       mode,
  input  logic            wide,
  input  logic            byte_hi,
  input  rd_src_e         src,
  input  logic [1:0]      addr_lo,
  input  logic [DQ_W-1:0] array_data,
  input  logic [7:0]      status_byte,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe
);

  localparam int LANE_W = DQ_W / 2;
  localparam int LANES  = 2;

  logic [LANE_W-1:0] lane_val [LANES];
  logic [LANES-1:0]  lane_en;
  logic              reading;
  logic [7:0]        id_byte;

  assign reading = (mode == M_READ);
  assign id_byte = ident_code(addr_lo, MFR_CODE, DEV_CODE);

  // Low lane: source-dependent, with byte pick in narrow width.
  always_comb begin
    lane_val[0] = '0;
    case (src)
      SRC_IDENT:  lane_val[0] = LANE_W'(id_byte);
      SRC_STATUS: lane_val[0] = LANE_W'(status_byte);
      default:    lane_val[0] = (!wide && byte_hi) ? array_data[DQ_W-1:LANE_W]
                                                   : array_data[LANE_W-1:0];
    endcase
  end

  // High lane: only array data carries a non-zero upper half.
  always_comb begin
    lane_val[1] = '0;
    if (src == SRC_ARRAY) lane_val[1] = array_data[DQ_W-1:LANE_W];
  end

  assign lane_en[0] = reading;
  assign lane_en[1] = reading && wide && (src != SRC_STATUS);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_out[g*LANE_W +: LANE_W] = lane_en[g] ? lane_val[g] : '0;
    assign dq_oe [g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
  end

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STANDBY) |-> (dq_oe == '0));                           // R1
  AST_OUT_OFF_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OUT_OFF) |-> (dq_oe == '0));                           // R2
  AST_NARROW_HIGH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (dq_oe[DQ_W-1:LANE_W] == '0));                          // R4
  AST_STATUS_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_STATUS) |-> (dq_oe[DQ_W-1:LANE_W] == '0));            // R7
  AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WRITE) |-> (dq_oe == '0));                             // R8
  AST_CLASH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CLASH) |-> (dq_oe == '0));                             // R10

endmodule

// File: rtl/fbi_write_latch.sv
module fbi_write_latch
  import fbi_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  output logic              wr_valid,
  output logic [ADDR_W:0]   wr_addr,
  output logic [DQ_W-1:0]   wr_data
);

  localparam int LANE_W = DQ_W / 2;

  logic              strobe_on;
  logic              strobe_was;
  logic              strobe_end;
  logic [ADDR_W:0]   hold_addr;
  logic [DQ_W-1:0]   hold_data;

  assign strobe_on  = (mode == M_WRITE);
  assign strobe_end = strobe_was && !strobe_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_was <= 1'b0;
      hold_addr  <= '0;
      hold_data  <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      strobe_was <= strobe_on;
      if (strobe_on) begin
        hold_addr <= {addr, (wide ? 1'b0 : dq[DQ_W-1])};
        hold_data <= wide ? dq : {{LANE_W{1'b0}}, dq[LANE_W-1:0]};
      end
      wr_valid <= strobe_end;
      if (strobe_end) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
      end
    end
  end

  AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);                                          // R8
  AST_STANDBY_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_STANDBY) && $past(mode == M_STANDBY)) |=> !wr_valid); // R1
  AST_CLASH_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_CLASH) && $past(mode == M_CLASH)) |=> !wr_valid);     // R10

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import fbi_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         DQ_W     = 16,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe,
  input  logic [1:0]        rd_src,
  input  logic [DQ_W-1:0]   array_data,
  input  logic [7:0]        status_byte,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              wr_valid,
  output logic [ADDR_W:0]   wr_addr,
  output logic [DQ_W-1:0]   wr_data
);

  logic              s_ce_n, s_oe_n, s_we_n, s_wide, s_id;
  logic [1:0]        s_src;
  logic [ADDR_W-1:0] s_addr;
  logic [DQ_W-1:0]   s_dq;
  bus_mode_e         bus_mode;
  rd_src_e           eff_src;

  fbi_pin_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_sample (
    .clk(clk), .rst_n(rst_n),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wide(wide), .id_mode(id_mode),
    .rd_src(rd_src), .addr(addr), .dq_in(dq_in),
    .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n), .s_wide(s_wide),
    .s_id(s_id), .s_src(s_src), .s_addr(s_addr), .s_dq(s_dq)
  );

  assign bus_mode = decode_mode(s_ce_n, s_oe_n, s_we_n);
  assign eff_src  = resolve_src(s_id, s_src);
  assign arr_addr = s_addr;

  fbi_read_steer #(.DQ_W(DQ_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .mode(bus_mode), .wide(s_wide), .byte_hi(s_dq[DQ_W-1]), .src(eff_src),
    .addr_lo(s_addr[1:0]), .array_data(array_data), .status_byte(status_byte),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  fbi_write_latch #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_wlatch (
    .clk(clk), .rst_n(rst_n),
    .mode(bus_mode), .wide(s_wide), .addr(s_addr), .dq(s_dq),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  AST_ID_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    s_id |-> (eff_src == SRC_IDENT));                                 // R5

endmodule

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;

  localparam int AW = 20;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide = 1'b1, id_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [1:0] rd_src = 2'd0;
  logic [7:0] status_byte = 8'h00;
  logic [15:0] array_data, dq_out, dq_oe, wr_data;
  logic [AW-1:0] arr_addr;
  logic [AW:0] wr_addr;
  logic wr_valid;

  int total = 0, bad = 0, exp_pulses = 0, got_pulses = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] aw(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + {4'h0, a[19:16]}};
  endfunction
  assign array_data = aw(arr_addr);

  flash_bus_front i_flash_bus_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wide(wide), .id_mode(id_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_src(rd_src), .array_data(array_data),
    .status_byte(status_byte), .arr_addr(arr_addr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct packed {
    logic c, o, w, wd, id;
    logic [1:0] src;
    logic [AW-1:0] a;
    logic [15:0] d;
  } smp_t;
  localparam smp_t IDLE = '{c:1'b1, o:1'b1, w:1'b1, wd:1'b1, id:1'b0, src:2'd0, a:'0, d:'0};
  smp_t h1 = IDLE, h2 = IDLE, h3 = IDLE;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 <= IDLE; h2 <= IDLE; h3 <= IDLE;
    end else begin
      h1 <= '{c:ce_n, o:oe_n, w:we_n, wd:wide, id:id_mode, src:rd_src, a:addr, d:dq_in};
      h2 <= h1; h3 <= h2;
    end
  end

  function automatic bit is_wr(smp_t s);
    return !s.c && !s.w && s.o;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle reference compare
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string rq;
      logic [15:0] e_oe, e_out;
      logic [7:0] code;
      e_oe = 16'h0000; e_out = 16'h0000;
      code = (h1.a[1:0] == 2'b00) ? 8'hC2 : (h1.a[1:0] == 2'b01) ? 8'hF7 : 8'h00;
      if (h1.c) rq = "R1";
      else if (!h1.o && !h1.w) rq = "R10";
      else if (!h1.w) rq = "R8";
      else if (h1.o) rq = "R2";
      else if (h1.id || h1.src == 2'd1) begin
        rq = h1.wd ? "R5" : "R6";
        if (h1.wd) begin e_oe = 16'hFFFF; e_out = {8'h00, code}; end
        else begin e_oe = 16'h00FF; e_out = {8'h00, code}; end
      end else if (h1.src == 2'd2) begin
        rq = "R7"; e_oe = 16'h00FF; e_out = {8'h00, status_byte};
      end else begin
        logic [15:0] wv;
        wv = aw(h1.a);
        rq = (h1.src == 2'd3) ? "R11" : (h1.wd ? "R3" : "R4");
        if (h1.wd) begin e_oe = 16'hFFFF; e_out = wv; end
        else begin e_oe = 16'h00FF; e_out = {8'h00, h1.d[15] ? wv[15:8] : wv[7:0]}; end
      end
      check(rq, 64'(dq_oe), 64'(e_oe));
      check(rq, 64'(dq_out & dq_oe), 64'(e_out));
      check("R3_addr", 64'(arr_addr), 64'(h1.a));
      begin
        bit ew;
        ew = is_wr(h3) && !is_wr(h2);
        check("R8_valid", 64'(wr_valid), 64'(ew));
        if (ew) begin
          exp_pulses++;
          if (h3.wd) begin
            check("R8_addr", 64'(wr_addr), 64'({h3.a, 1'b0}));
            check("R8_data", 64'(wr_data), 64'(h3.d));
          end else begin
            check("R9_addr", 64'(wr_addr), 64'({h3.a, h3.d[15]}));
            check("R9_data", 64'(wr_data), 64'({8'h00, h3.d[7:0]}));
          end
        end
        if (wr_valid) got_pulses++;
      end
    end
  end

  task automatic drive(logic c, logic o, logic w, logic wd, logic idp, logic [1:0] s,
                       logic [AW-1:0] a, logic [15:0] d, int n);
    @(posedge clk); #2;
    ce_n = c; oe_n = o; we_n = w; wide = wd; id_mode = idp; rd_src = s;
    addr = a; dq_in = d;
    repeat (n - 1) @(posedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #8;
    check("R12_oe", 64'(dq_oe), 64'h0);
    check("R12_wr", 64'(wr_valid), 64'h0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    check("R12_oe_after", 64'(dq_oe), 64'h0);
    // R1 standby with other strobes low
    drive(1, 0, 0, 1, 0, 0, 20'h00123, 16'h1111, 3);
    drive(1, 0, 1, 0, 1, 2, 20'h00001, 16'h8000, 2);
    // R2 output off
    drive(0, 1, 1, 1, 0, 0, 20'h00010, 16'h0, 2);
    // R3 wide array reads
    for (int i = 0; i < 6; i++) drive(0, 0, 1, 1, 0, 0, 20'(i * 20'h1357B), 16'h0, 1);
    // R4 narrow reads, both halves
    for (int i = 0; i < 6; i++) drive(0, 0, 1, 0, 0, 0, 20'(20'hA0F3 + i), {i[0], 15'h1234}, 1);
    // R5/R6 identifier via pin and via source, both widths, all selectors
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 1, 1, 1, 2, 20'(20'h40 + i), 16'h0, 1);
      drive(0, 0, 1, 0, 1, 0, 20'(20'h40 + i), 16'h8000, 1);
      drive(0, 0, 1, 1, 0, 1, 20'(i), 16'h0, 1);
    end
    // R7 status in both widths; R11 spare source
    status_byte = 8'h9C;
    drive(0, 0, 1, 1, 0, 2, 20'h5, 16'h0, 2);
    drive(0, 0, 1, 0, 0, 2, 20'h5, 16'h8000, 2);
    drive(0, 0, 1, 1, 0, 3, 20'h2468A, 16'h0, 2);
    // R8 wide write ended by write enable
    drive(0, 1, 0, 1, 0, 0, 20'h12345, 16'hBEEF, 2);
    drive(0, 1, 0, 1, 0, 0, 20'h12346, 16'hCAFE, 1);
    drive(0, 1, 1, 1, 0, 0, 20'h0, 16'h0, 4);
    // R9 narrow writes, low and high byte
    drive(0, 1, 0, 0, 0, 0, 20'h00AA0, 16'h0055, 1);
    drive(0, 1, 1, 0, 0, 0, 20'h0, 16'h0, 3);
    drive(0, 1, 0, 0, 0, 0, 20'h00AA1, 16'h8077, 2);
    drive(1, 1, 1, 0, 0, 0, 20'h0, 16'h0, 4);
    // R8 write ended by chip select rising
    drive(0, 1, 0, 1, 0, 0, 20'hFFFFF, 16'h0F0F, 2);
    drive(1, 1, 0, 1, 0, 0, 20'h0, 16'h0, 4);
    // R10 clash from idle, then clash after a write
    drive(0, 0, 0, 1, 0, 0, 20'h77, 16'hFFFF, 4);
    drive(1, 1, 1, 1, 0, 0, 20'h0, 16'h0, 2);
    drive(0, 1, 0, 1, 0, 0, 20'h33, 16'h4242, 2);
    drive(0, 0, 0, 1, 0, 0, 20'h33, 16'h4242, 3);
    drive(1, 1, 1, 1, 0, 0, 20'h0, 16'h0, 4);
    @(negedge clk);
    check("R8_count", 64'(got_pulses), 64'(exp_pulses));
    check("R8_seen", 64'(exp_pulses >= 5), 64'd1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule